// File: doc/BRIEF.md
# Pipelined Trajectory Rollout Cost Engine

This block scores sampled control trajectories for a sampling-based predictive controller. A host first fills local storage with a starting state, a target position, one nominal control per horizon step, and a perturbation word for every (step, sample) pair. A single start pulse then sends a batch of samples into the engine, one per clock. The plant is a one-dimensional double integrator (position, velocity) in signed Q8.8 fixed point. Each sample is driven through it by the nominal control plus that sample's perturbation.

The horizon loop is fully unrolled. There is one register stage per time step, which advances the plant and adds the running cost. One more stage adds the terminal cost. Once the pipe has filled, one total cost leaves on every clock, tagged with its sample index. A done flag shows that the batch has drained. The block contains no random number generation, exponentials or reductions. Weighting of the costs and the control update are left to the consumer.

Top module: `rollout_cost_engine`

## Requirements
- R1: While reset is applied and after it is released, cost_valid and done are 0 until a start is accepted.
- R2: A start accepted with last_sample = M launches the samples 0..M in ascending order. Their costs appear on M+1 consecutive cycles with cost_sample counting up from 0.
- R3: The first cost of a batch becomes valid after the (HORIZON+1)-th rising edge that follows the edge which samples start. No cost is valid before that edge.
- R4: At step t, the control is u = nominal[t] + perturbation[t][sample], with 16-bit wrap. The state then advances as pos' = pos + (vel >>> DT_SHIFT) and vel' = vel + (u >>> DT_SHIFT), both with 16-bit two's-complement wrap.
- R5: At step t, the running cost added is floor(Q_WEIGHT*(pos_t - ref)^2 / 256) + floor(R_WEIGHT*u_t^2 / 256). It uses the state before that step's update.
- R6: After the last step, the terminal cost floor(T_WEIGHT*(pos_H - ref)^2 / 256) + floor(V_WEIGHT*vel_H^2 / 256) is added to the sum of the running costs.
- R7: Every accumulation saturates at 2^COST_W - 1 and never wraps.
- R8: done rises on the cycle after the batch's last valid cost. It stays high until the next accepted start, and it is 0 on the cycle after that start is sampled.
- R9: A start pulse while a batch is still in flight is ignored. The running batch keeps its sample count and order.
- R10: The host writes one word per cycle when wr_en is 1. wr_kind 0 stores wr_data as the perturbation for (wr_step, wr_sample). wr_kind 1 stores it as the nominal control of step wr_step. wr_kind 2 stores a scalar selected by wr_step: 0 is the start position, 1 is the start velocity, 2 is the reference position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_kind | input | 2 | Write target: 0 perturbation, 1 nominal, 2 scalar |
| wr_step | input | 5 | Horizon step, or scalar selector |
| wr_sample | input | 4 | Sample index for perturbation writes |
| wr_data | input | 16 | Q8.8 write data |
| start | input | 1 | Launch a batch (accepted only when idle or done) |
| last_sample | input | 4 | Index of the last sample in the batch |
| cost_valid | output | 1 | A total cost is presented this cycle |
| cost_sample | output | 4 | Sample index of the presented cost |
| cost_value | output | 24 | Saturated total trajectory cost |
| done | output | 1 | The batch has fully drained |

## Verification
The hardest case to reach is a start pulse that arrives while a batch is still in the pipe. The samples already launched and those still to be launched then sit in stages that overlap in time. The stimulus raises start a few cycles into a run, with a different sample count, and checks that the number, order and timing of the outputs and the done cycle are unchanged. Saturation is reached by placing the start position and the reference at opposite ends of the Q8.8 range. This makes a single step's error term larger than the accumulator can hold.

// File: rtl/rollout_pkg.sv
package rollout_pkg;

  localparam logic [1:0] KIND_NOISE   = 2'd0;
  localparam logic [1:0] KIND_NOMINAL = 2'd1;
  localparam logic [1:0] KIND_SCALAR  = 2'd2;

  localparam int SEL_POS0 = 0;
  localparam int SEL_VEL0 = 1;
  localparam int SEL_REF  = 2;

  typedef enum logic [1:0] {
    LS_IDLE  = 2'd0,
    LS_ISSUE = 2'd1,
    LS_DRAIN = 2'd2,
    LS_DONE  = 2'd3
  } launch_state_e;

endpackage

// File: rtl/rollout_noise_bank.sv
module rollout_noise_bank #(
  parameter int DEPTH  = 16,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/rollout_launcher.sv
module rollout_launcher
  import rollout_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] last_sample,
  input  logic             fin,
  output logic             iss_valid,
  output logic             iss_last,
  output logic [IDX_W-1:0] iss_idx,
  output logic             done
);

  launch_state_e    state_q, state_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] lim_q, lim_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    lim_d   = lim_q;
    unique case (state_q)
      LS_IDLE, LS_DONE: begin
        if (start) begin
          state_d = LS_ISSUE;
          cnt_d   = '0;
          lim_d   = last_sample;
        end
      end
      LS_ISSUE: begin
        if (cnt_q == lim_q) begin
          state_d = LS_DRAIN;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      LS_DRAIN: begin
        if (fin) begin
          state_d = LS_DONE;
        end
      end
      default: state_d = LS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LS_IDLE;
      cnt_q   <= '0;
      lim_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      lim_q   <= lim_d;
    end
  end

  assign iss_valid = (state_q == LS_ISSUE);
  assign iss_last  = (cnt_q == lim_q);
  assign iss_idx   = cnt_q;
  assign done      = (state_q == LS_DONE);

endmodule

// File: rtl/rollout_step_stage.sv
module rollout_step_stage #(
  parameter int DATA_W   = 16,
  parameter int FRAC_W   = 8,
  parameter int COST_W   = 24,
  parameter int IDX_W    = 4,
  parameter int DT_SHIFT = 3,
  parameter int WT_W     = 8,
  parameter int Q_WEIGHT = 2,
  parameter int R_WEIGHT = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_last,
  input  logic [IDX_W-1:0]         in_idx,
  input  logic signed [DATA_W-1:0] in_pos,
  input  logic signed [DATA_W-1:0] in_vel,
  input  logic [COST_W-1:0]        in_acc,
  input  logic signed [DATA_W-1:0] nominal,
  input  logic signed [DATA_W-1:0] noise,
  input  logic signed [DATA_W-1:0] ref_pos,
  output logic                     out_valid,
  output logic                     out_last,
  output logic [IDX_W-1:0]         out_idx,
  output logic signed [DATA_W-1:0] out_pos,
  output logic signed [DATA_W-1:0] out_vel,
  output logic [COST_W-1:0]        out_acc
);

  localparam int SQ_W   = 2 * (DATA_W + 1);
  localparam int TERM_W = SQ_W + WT_W;
  localparam logic [TERM_W:0] SUM_CAP = (TERM_W+1)'({COST_W{1'b1}});

  logic signed [DATA_W-1:0] u;
  logic signed [DATA_W:0]   err;
  logic signed [SQ_W-1:0]   err_x, u_x, err_sq, u_sq;
  logic [TERM_W-1:0]        q_prod, r_prod;
  logic [TERM_W:0]          sum;
  logic signed [DATA_W-1:0] pos_d, vel_d;
  logic [COST_W-1:0]        acc_d;
  logic                     valid_q, last_q;
  logic [IDX_W-1:0]         idx_q;
  logic signed [DATA_W-1:0] pos_q, vel_q;
  logic [COST_W-1:0]        acc_q;

  always_comb begin
    u      = nominal + noise;
    pos_d  = in_pos + (in_vel >>> DT_SHIFT);
    vel_d  = in_vel + (u >>> DT_SHIFT);
    err    = {in_pos[DATA_W-1], in_pos} - {ref_pos[DATA_W-1], ref_pos};
    err_x  = SQ_W'(err);
    u_x    = SQ_W'(u);
    err_sq = err_x * err_x;
    u_sq   = u_x * u_x;
    q_prod = TERM_W'($unsigned(err_sq)) * TERM_W'(Q_WEIGHT);
    r_prod = TERM_W'($unsigned(u_sq)) * TERM_W'(R_WEIGHT);
    sum    = (TERM_W+1)'(in_acc) + (TERM_W+1)'(q_prod >> FRAC_W)
           + (TERM_W+1)'(r_prod >> FRAC_W);
    acc_d  = (sum > SUM_CAP) ? {COST_W{1'b1}} : sum[COST_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      last_q <= in_last;
      idx_q  <= in_idx;
      pos_q  <= pos_d;
      vel_q  <= vel_d;
      acc_q  <= acc_d;
    end
  end

  assign out_valid = valid_q;
  assign out_last  = last_q;
  assign out_idx   = idx_q;
  assign out_pos   = pos_q;
  assign out_vel   = vel_q;
  assign out_acc   = acc_q;

endmodule

// File: rtl/rollout_term_stage.sv
module rollout_term_stage #(
  parameter int DATA_W   = 16,
  parameter int FRAC_W   = 8,
  parameter int COST_W   = 24,
  parameter int IDX_W    = 4,
  parameter int WT_W     = 8,
  parameter int T_WEIGHT = 4,
  parameter int V_WEIGHT = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_last,
  input  logic [IDX_W-1:0]         in_idx,
  input  logic signed [DATA_W-1:0] in_pos,
  input  logic signed [DATA_W-1:0] in_vel,
  input  logic [COST_W-1:0]        in_acc,
  input  logic signed [DATA_W-1:0] ref_pos,
  output logic                     out_valid,
  output logic                     out_last,
  output logic [IDX_W-1:0]         out_idx,
  output logic [COST_W-1:0]        out_cost
);

  localparam int SQ_W   = 2 * (DATA_W + 1);
  localparam int TERM_W = SQ_W + WT_W;
  localparam logic [TERM_W:0] SUM_CAP = (TERM_W+1)'({COST_W{1'b1}});

  logic signed [DATA_W:0] err;
  logic signed [SQ_W-1:0] err_x, vel_x, err_sq, vel_sq;
  logic [TERM_W-1:0]      t_prod, v_prod;
  logic [TERM_W:0]        sum;
  logic [COST_W-1:0]      cost_d;
  logic                   valid_q, last_q;
  logic [IDX_W-1:0]       idx_q;
  logic [COST_W-1:0]      cost_q;

  always_comb begin
    err    = {in_pos[DATA_W-1], in_pos} - {ref_pos[DATA_W-1], ref_pos};
    err_x  = SQ_W'(err);
    vel_x  = SQ_W'(in_vel);
    err_sq = err_x * err_x;
    vel_sq = vel_x * vel_x;
    t_prod = TERM_W'($unsigned(err_sq)) * TERM_W'(T_WEIGHT);
    v_prod = TERM_W'($unsigned(vel_sq)) * TERM_W'(V_WEIGHT);
    sum    = (TERM_W+1)'(in_acc) + (TERM_W+1)'(t_prod >> FRAC_W)
           + (TERM_W+1)'(v_prod >> FRAC_W);
    cost_d = (sum > SUM_CAP) ? {COST_W{1'b1}} : sum[COST_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      idx_q   <= '0;
      cost_q  <= '0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        last_q <= in_last;
        idx_q  <= in_idx;
        cost_q <= cost_d;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_last  = last_q;
  assign out_idx   = idx_q;
  assign out_cost  = cost_q;

endmodule

// File: rtl/rollout_cost_engine.sv
module rollout_cost_engine
  import rollout_pkg::*;
#(
  parameter int HORIZON     = 25,
  parameter int MAX_SAMPLES = 16,
  parameter int DATA_W      = 16,
  parameter int FRAC_W      = 8,
  parameter int COST_W      = 24,
  parameter int DT_SHIFT    = 3,
  parameter int WT_W        = 8,
  parameter int Q_WEIGHT    = 2,
  parameter int R_WEIGHT    = 1,
  parameter int T_WEIGHT    = 4,
  parameter int V_WEIGHT    = 1,
  localparam int STEP_W     = (HORIZON > 4) ? $clog2(HORIZON) : 2,
  localparam int IDX_W      = (MAX_SAMPLES > 1) ? $clog2(MAX_SAMPLES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_kind,
  input  logic [STEP_W-1:0] wr_step,
  input  logic [IDX_W-1:0]  wr_sample,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              start,
  input  logic [IDX_W-1:0]  last_sample,
  output logic              cost_valid,
  output logic [IDX_W-1:0]  cost_sample,
  output logic [COST_W-1:0] cost_value,
  output logic              done
);

  logic signed [DATA_W-1:0] nom_q [HORIZON];
  logic signed [DATA_W-1:0] pos0_q, vel0_q, ref_q;
  logic                     nom_we, scalar_we;

  logic                     st_valid [HORIZON+1];
  logic                     st_last  [HORIZON+1];
  logic [IDX_W-1:0]         st_idx   [HORIZON+1];
  logic signed [DATA_W-1:0] st_pos   [HORIZON+1];
  logic signed [DATA_W-1:0] st_vel   [HORIZON+1];
  logic [COST_W-1:0]        st_acc   [HORIZON+1];

  logic                     cost_last;

  assign nom_we    = wr_en && (wr_kind == KIND_NOMINAL);
  assign scalar_we = wr_en && (wr_kind == KIND_SCALAR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos0_q <= '0;
      vel0_q <= '0;
      ref_q  <= '0;
    end else if (scalar_we) begin
      if (wr_step == STEP_W'(SEL_POS0)) pos0_q <= wr_data;
      if (wr_step == STEP_W'(SEL_VEL0)) vel0_q <= wr_data;
      if (wr_step == STEP_W'(SEL_REF))  ref_q  <= wr_data;
    end
  end

  rollout_launcher #(.IDX_W(IDX_W)) u_launch (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .last_sample (last_sample),
    .fin         (cost_valid && cost_last),
    .iss_valid   (st_valid[0]),
    .iss_last    (st_last[0]),
    .iss_idx     (st_idx[0]),
    .done        (done)
  );

  assign st_pos[0] = pos0_q;
  assign st_vel[0] = vel0_q;
  assign st_acc[0] = '0;

  for (genvar k = 0; k < HORIZON; k++) begin : g_step
    logic [DATA_W-1:0] noise_word;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        nom_q[k] <= '0;
      end else if (nom_we && (wr_step == STEP_W'(k))) begin
        nom_q[k] <= wr_data;
      end
    end

    rollout_noise_bank #(
      .DEPTH  (MAX_SAMPLES),
      .IDX_W  (IDX_W),
      .DATA_W (DATA_W)
    ) u_bank (
      .clk   (clk),
      .we    (wr_en && (wr_kind == KIND_NOISE) && (wr_step == STEP_W'(k))),
      .waddr (wr_sample),
      .wdata (wr_data),
      .raddr (st_idx[k]),
      .rdata (noise_word)
    );

    rollout_step_stage #(
      .DATA_W   (DATA_W),
      .FRAC_W   (FRAC_W),
      .COST_W   (COST_W),
      .IDX_W    (IDX_W),
      .DT_SHIFT (DT_SHIFT),
      .WT_W     (WT_W),
      .Q_WEIGHT (Q_WEIGHT),
      .R_WEIGHT (R_WEIGHT)
    ) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (st_valid[k]),
      .in_last   (st_last[k]),
      .in_idx    (st_idx[k]),
      .in_pos    (st_pos[k]),
      .in_vel    (st_vel[k]),
      .in_acc    (st_acc[k]),
      .nominal   (nom_q[k]),
      .noise     (noise_word),
      .ref_pos   (ref_q),
      .out_valid (st_valid[k+1]),
      .out_last  (st_last[k+1]),
      .out_idx   (st_idx[k+1]),
      .out_pos   (st_pos[k+1]),
      .out_vel   (st_vel[k+1]),
      .out_acc   (st_acc[k+1])
    );
  end

  rollout_term_stage #(
    .DATA_W   (DATA_W),
    .FRAC_W   (FRAC_W),
    .COST_W   (COST_W),
    .IDX_W    (IDX_W),
    .WT_W     (WT_W),
    .T_WEIGHT (T_WEIGHT),
    .V_WEIGHT (V_WEIGHT)
  ) u_term (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (st_valid[HORIZON]),
    .in_last   (st_last[HORIZON]),
    .in_idx    (st_idx[HORIZON]),
    .in_pos    (st_pos[HORIZON]),
    .in_vel    (st_vel[HORIZON]),
    .in_acc    (st_acc[HORIZON]),
    .ref_pos   (ref_q),
    .out_valid (cost_valid),
    .out_last  (cost_last),
    .out_idx   (cost_sample),
    .out_cost  (cost_value)
  );

endmodule

// File: rtl/rollout_cost_engine_chk.sv
module rollout_cost_engine_chk #(
  parameter int HORIZON = 25,
  parameter int IDX_W   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             cost_valid,
  input logic [IDX_W-1:0] cost_sample,
  input logic             done
);

  localparam int FIRST = HORIZON + 2;
  localparam int CNT_W = $clog2(FIRST + 1);

  logic             busy_q;
  logic             accept;
  logic [CNT_W-1:0] lat_q;

  assign accept = start && !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      lat_q  <= '0;
    end else begin
      if (accept) busy_q <= 1'b1;
      else if (done) busy_q <= 1'b0;
      if (accept) lat_q <= CNT_W'(1);
      else if (lat_q == CNT_W'(FIRST)) lat_q <= '0;
      else if (lat_q != '0) lat_q <= lat_q + 1'b1;
    end
  end

  assert_first_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cost_valid) |-> (cost_sample == '0));

  assert_index_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cost_valid && $past(cost_valid)) |-> (cost_sample == IDX_W'($past(cost_sample) + 1'b1)));

  assert_fill_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((lat_q != '0) && (lat_q < CNT_W'(FIRST))) |-> !cost_valid);

  assert_fill_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q == CNT_W'(FIRST)) |-> (cost_valid && cost_sample == '0));

  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(cost_valid));

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cost_valid);

  assert_done_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(start));

endmodule

bind rollout_cost_engine rollout_cost_engine_chk #(
  .HORIZON (HORIZON),
  .IDX_W   (IDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .cost_valid  (cost_valid),
  .cost_sample (cost_sample),
  .done        (done)
);

// File: tb/tb_rollout_cost_engine.sv
module tb_rollout_cost_engine;

  localparam int  CLK_PERIOD = 10;
  localparam int  H     = 25;
  localparam int  NS    = 16;
  localparam int  CW    = 24;
  localparam int  DTS   = 3;
  localparam int  QW    = 2;
  localparam int  RW    = 1;
  localparam int  TW    = 4;
  localparam int  VW    = 1;
  localparam longint CMAX = (longint'(1) << CW) - 1;

  logic        clk, rst_n;
  logic        wr_en;
  logic [1:0]  wr_kind;
  logic [4:0]  wr_step;
  logic [3:0]  wr_sample;
  logic [15:0] wr_data;
  logic        start;
  logic [3:0]  last_sample;
  logic        cost_valid;
  logic [3:0]  cost_sample;
  logic [CW-1:0] cost_value;
  logic        done;

  int checks = 0;
  int failures = 0;

  logic signed [15:0] b_noise [H][NS];
  logic signed [15:0] b_nom [H];
  logic signed [15:0] b_pos0, b_vel0, b_ref;

  rollout_cost_engine #(
    .HORIZON(H), .MAX_SAMPLES(NS), .DATA_W(16), .FRAC_W(8), .COST_W(CW),
    .DT_SHIFT(DTS), .WT_W(8), .Q_WEIGHT(QW), .R_WEIGHT(RW),
    .T_WEIGHT(TW), .V_WEIGHT(VW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
    .wr_step(wr_step), .wr_sample(wr_sample), .wr_data(wr_data),
    .start(start), .last_sample(last_sample), .cost_valid(cost_valid),
    .cost_sample(cost_sample), .cost_value(cost_value), .done(done)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog (all R) actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sat(input longint v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  // Independent model of R4, R5, R6 and R7
  function automatic longint model_cost(input int i);
    logic signed [15:0] p, v, u;
    longint acc, e, uu, vv;
    p = b_pos0; v = b_vel0; acc = 0;
    for (int t = 0; t < H; t++) begin
      u  = b_nom[t] + b_noise[t][i];
      e  = longint'(p) - longint'(b_ref);
      uu = longint'(u);
      acc = sat(acc + ((QW * e * e) >> 8) + ((RW * uu * uu) >> 8));
      p = p + (v >>> DTS);
      v = v + (u >>> DTS);
    end
    e  = longint'(p) - longint'(b_ref);
    vv = longint'(v);
    acc = sat(acc + ((TW * e * e) >> 8) + ((VW * vv * vv) >> 8));
    return acc;
  endfunction

  task automatic host_write(input logic [1:0] kind, input int step, input int smp, input logic [15:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = kind; wr_step = 5'(step); wr_sample = 4'(smp); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // R10: kind 0 perturbation, kind 1 nominal, kind 2 scalar (0 pos, 1 vel, 2 ref)
  task automatic load_all();
    host_write(2'd2, 0, 0, b_pos0);
    host_write(2'd2, 1, 0, b_vel0);
    host_write(2'd2, 2, 0, b_ref);
    for (int t = 0; t < H; t++) begin
      host_write(2'd1, t, 0, b_nom[t]);
      for (int s = 0; s < NS; s++) host_write(2'd0, t, s, b_noise[t][s]);
    end
  endtask

  task automatic run_batch(input int last, input int restart_at);
    int seen = 0;
    int done_cyc = -1;
    longint exp_v;
    @(negedge clk);
    start = 1'b1; last_sample = 4'(last);
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R8 done cleared after start", longint'(done), 0);
    for (int cyc = 1; cyc <= H + last + 8; cyc++) begin
      if (cost_valid) begin
        exp_v = model_cost(seen);
        check(int'(cost_sample) == seen, "R2 sample order", longint'(cost_sample), seen);
        check(cyc == H + 2 + seen, "R3 output cycle", cyc, H + 2 + seen);
        check(longint'(cost_value) == exp_v, "R5 R6 total cost", longint'(cost_value), exp_v);
        seen++;
      end
      if (done && done_cyc < 0) done_cyc = cyc;
      if (cyc == restart_at) begin start = 1'b1; last_sample = 4'(2); end
      if (cyc == restart_at + 1) start = 1'b0;
      @(negedge clk);
    end
    check(seen == last + 1, "R2 R9 output count", seen, last + 1);
    check(done_cyc == H + 3 + last, "R8 done cycle", done_cyc, H + 3 + last);
    check(done == 1'b1, "R8 done holds", longint'(done), 1);
  endtask

  task automatic test_reset();
    check(cost_valid == 1'b0, "R1 cost_valid in reset", longint'(cost_valid), 0);
    check(done == 1'b0, "R1 done in reset", longint'(done), 0);
  endtask

  task automatic test_basic();
    b_pos0 = 16'sh0100; b_vel0 = 16'sh0080; b_ref = 16'sh0200;
    for (int t = 0; t < H; t++) begin
      b_nom[t] = 16'(t * 4);
      for (int s = 0; s < NS; s++) b_noise[t][s] = 16'((s - 8) * 16 + t);
    end
    load_all();
    run_batch(3, -10);
  endtask

  task automatic test_full_batch();
    for (int t = 0; t < H; t++)
      for (int s = 0; s < NS; s++) b_noise[t][s] = 16'(((s * 37 + t * 11) % 97) * 8 - 300);
    load_all();
    run_batch(NS - 1, -10);
  endtask

  task automatic test_single();
    run_batch(0, -10);
  endtask

  task automatic test_restart_ignored();
    run_batch(5, 4);
  endtask

  task automatic test_saturation();
    b_pos0 = 16'sh7F00; b_vel0 = 16'sh0000; b_ref = 16'sh8100;
    for (int t = 0; t < H; t++) begin
      b_nom[t] = 16'sh0000;
      for (int s = 0; s < NS; s++) b_noise[t][s] = 16'sh0000;
    end
    load_all();
    check(model_cost(0) == CMAX, "R7 model saturates", model_cost(0), CMAX);
    run_batch(1, -10);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_kind = '0; wr_step = '0; wr_sample = '0;
    wr_data = '0; start = 1'b0; last_sample = '0;
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_basic();
    test_full_batch();
    test_single();
    test_restart_ignored();
    test_saturation();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule